// File: doc/BRIEF.md
# I2S Slave Receive Channel

This block receives audio as the slave on an I2S link. The external master drives the bit clock, the word-select line and the serial data line, and the block follows them. It brings all three into the system clock domain and finds the bit-clock rising edges there. It then follows the channel framing set by word-select and cuts the serial stream into 16-bit packets. Each packet is tagged with the channel it belongs to.

Packets go out through a one-deep buffer on a valid/ready port. `pkt_valid` is the receive-not-empty flag. A packet counts as read in any cycle where `pkt_valid` and `pkt_ready` are both high. Back-pressure works like this: while the reader keeps `pkt_ready` low, the held packet stays unchanged. A packet that completes during that time is dropped and raises the overrun flag. Two interrupt outputs are available, each gated by its own enable: a receive interrupt and an error interrupt. A busy flag shows that a transfer is in progress, except in the master-receive configuration code.

Top module: `i2s_slave_rx`

## Requirements
- R1: Serial data is sampled on bit-clock rising edges, MSB first. The first bit of a word is the one sampled at the rising edge after the edge where word-select is first seen at its new level. The bit sampled at that change edge is the LSB of the word that is ending.
- R2: A channel longer than 16 bits arrives as consecutive 16-bit packets. A 32-bit channel gives its upper half and then its lower half, and both packets carry the same channel flag.
- R3: `pkt_right` shows the word-select level sampled with the first bit of the packet: 0 means left, 1 means right.
- R4: `pkt_valid` rises when a packet completes while the buffer is empty. `irq_rx` is high exactly while `pkt_valid` and `rxne_ie` are both 1.
- R5: A cycle with `pkt_valid` and `pkt_ready` both high reads the packet and clears `pkt_valid`. While the packet is not read, `pkt_data` and `pkt_right` hold steady.
- R6: When a packet completes while an unread packet is held, `ovr_flag` is set, the held packet is kept and the new one is dropped. `irq_err` is high exactly while `ovr_flag` and `err_ie` are both 1.
- R7: `ovr_flag` clears only when a packet read that happened while the flag was set is followed by a pulse on `stat_rd`. A `stat_rd` pulse on its own leaves the flag set.
- R8: `busy` rises at the first word-select change seen while `rx_enable` is 1. It falls once `rx_enable` is 0 and no partial packet is in the shifter. No input drives it directly.
- R9: While `cfg_mode` is 2'b11, `busy` stays 0 and packets are still received.
- R10: After reset, `pkt_valid`, `ovr_flag`, `busy`, `irq_rx` and `irq_err` are all 0.
- R11: While `rx_enable` is 0 and the receiver is not busy, serial traffic produces no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i2s_bck | input | 1 | Bit clock from the external master (asynchronous) |
| i2s_ws | input | 1 | Word-select from the external master (asynchronous) |
| i2s_sd | input | 1 | Serial data (asynchronous) |
| rx_enable | input | 1 | Receiver enable |
| cfg_mode | input | 2 | Configuration code; 2'b11 keeps busy low |
| rxne_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| pkt_valid | output | 1 | Receive-not-empty: a packet is held |
| pkt_ready | input | 1 | Reader takes the packet this cycle |
| pkt_data | output | PKT_W | Held packet data |
| pkt_right | output | 1 | Channel of the held packet (1 = right) |
| stat_rd | input | 1 | Status-read strobe, second step of clearing overrun |
| ovr_flag | output | 1 | Overrun flag |
| busy | output | 1 | Transfer in progress |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The hardest state to reach from the ports is an overrun followed by the full two-step clear. The stimulus holds `pkt_ready` low while three packets stream in. It confirms that the first packet is still the one on offer and that a lone `stat_rd` leaves the flag set. Only then does it let the scoreboard monitor read the packet and pulse `stat_rd` again. The word-select framing is exercised with a change slot that carries a dummy bit at the start of each stream, so the bit-alignment rule of R1 is checked on the very first packet.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  localparam int PKT_W = 16;

  typedef struct packed {
    logic             right;
    logic [PKT_W-1:0] data;
  } pkt_t;
endpackage

// File: rtl/i2s_sync_edge.sv
module i2s_sync_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic         edge_rise
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_chan
    logic [STAGES:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-1:0], async_in[g]};
    end
    assign level[g] = sr[STAGES-1];
    assign prev[g]  = sr[STAGES];
  end

  assign edge_rise = level[0] & ~prev[0];
endmodule

// File: rtl/i2s_rx_shifter.sv
module i2s_rx_shifter
  import i2s_rx_pkg::*;
#(
  parameter int W = PKT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_rise,
  input  logic ws,
  input  logic sd,
  input  logic enable,
  output logic pkt_stb,
  output pkt_t pkt,
  output logic active
);
  localparam int CNT_W = $clog2(W);

  logic             ws_prev;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     shreg;
  logic             side;
  logic             change;

  assign change = ws != ws_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      side    <= 1'b0;
      active  <= 1'b0;
      pkt_stb <= 1'b0;
      pkt     <= '0;
    end else begin
      pkt_stb <= 1'b0;
      if (bit_rise) begin
        ws_prev <= ws;
        if (active) begin
          shreg <= {shreg[W-2:0], sd};
          if (cnt == '0) side <= ws;
          if (cnt == CNT_W'(W-1)) begin
            pkt_stb    <= 1'b1;
            pkt.data   <= {shreg[W-2:0], sd};
            pkt.right  <= side;
            cnt        <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (change) begin
          cnt <= '0;
          if (enable) active <= 1'b1;
        end
      end
      if (!enable && cnt == '0) active <= 1'b0;
    end
  end

  a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !active |=> !active);
endmodule

// File: rtl/i2s_pkt_buffer.sv
module i2s_pkt_buffer
  import i2s_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_stb,
  input  pkt_t in_pkt,
  input  logic rd,
  input  logic stat_rd,
  output logic valid,
  output pkt_t out_pkt,
  output logic ovr
);
  logic rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      out_pkt <= '0;
      ovr     <= 1'b0;
      rd_seen <= 1'b0;
    end else begin
      if (rd) begin
        valid <= 1'b0;
        if (ovr) rd_seen <= 1'b1;
      end
      if (stat_rd && rd_seen) begin
        ovr     <= 1'b0;
        rd_seen <= 1'b0;
      end
      if (in_stb) begin
        if (!valid || rd) begin
          valid   <= 1'b1;
          out_pkt <= in_pkt;
        end else begin
          ovr <= 1'b1;
        end
      end
    end
  end

  a_r4_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb && !valid |=> valid);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !rd && !in_stb |=> valid && $stable(out_pkt));
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb && valid && !rd |=> ovr && valid && $stable(out_pkt));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !stat_rd |=> ovr);
endmodule

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx
  import i2s_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i2s_bck,
  input  logic             i2s_ws,
  input  logic             i2s_sd,
  input  logic             rx_enable,
  input  logic [1:0]       cfg_mode,
  input  logic             rxne_ie,
  input  logic             err_ie,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [PKT_W-1:0] pkt_data,
  output logic             pkt_right,
  input  logic             stat_rd,
  output logic             ovr_flag,
  output logic             busy,
  output logic             irq_rx,
  output logic             irq_err
);
  localparam logic [1:0] MODE_MASTER_RX = 2'b11;

  logic [2:0] lvl;
  logic       bit_rise;
  logic       stb;
  pkt_t       new_pkt;
  pkt_t       held;
  logic       active;

  i2s_sync_edge #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  ({i2s_sd, i2s_ws, i2s_bck}),
    .level     (lvl),
    .edge_rise (bit_rise)
  );

  i2s_rx_shifter #(.W(PKT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_rise (bit_rise),
    .ws       (lvl[1]),
    .sd       (lvl[2]),
    .enable   (rx_enable),
    .pkt_stb  (stb),
    .pkt      (new_pkt),
    .active   (active)
  );

  i2s_pkt_buffer u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_stb  (stb),
    .in_pkt  (new_pkt),
    .rd      (pkt_valid && pkt_ready),
    .stat_rd (stat_rd),
    .valid   (pkt_valid),
    .out_pkt (held),
    .ovr     (ovr_flag)
  );

  assign pkt_data  = held.data;
  assign pkt_right = held.right;
  assign busy      = active && (cfg_mode != MODE_MASTER_RX);
  assign irq_rx    = pkt_valid && rxne_ie;
  assign irq_err   = ovr_flag && err_ie;
endmodule

// File: tb/test_i2s_slave_rx.sv
module test_i2s_slave_rx;
  localparam int PERIOD = 10;
  localparam int HALF   = 4;

  logic clk = 0, rst_n = 0;
  logic bck = 0, ws = 0, sd = 0;
  logic rx_enable = 0, rxne_ie = 0, err_ie = 0, pkt_ready = 0, stat_rd = 0;
  logic [1:0] cfg_mode = 2'b00;
  logic pkt_valid, pkt_right, ovr_flag, busy, irq_rx, irq_err;
  logic [15:0] pkt_data;

  int checks = 0, fails = 0;
  logic mon_en = 0;
  logic [16:0] q[$];

  always #(PERIOD/2) clk = ~clk;

  i2s_slave_rx i_i2s_slave_rx (
    .clk(clk), .rst_n(rst_n), .i2s_bck(bck), .i2s_ws(ws), .i2s_sd(sd),
    .rx_enable(rx_enable), .cfg_mode(cfg_mode), .rxne_ie(rxne_ie), .err_ie(err_ie),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .pkt_right(pkt_right), .stat_rd(stat_rd), .ovr_flag(ovr_flag), .busy(busy),
    .irq_rx(irq_rx), .irq_err(irq_err));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected packets and compares (R1, R2, R3, R5)
  initial forever begin
    @(negedge clk);
    pkt_ready = 0;
    if (mon_en && pkt_valid) begin
      logic [16:0] e;
      e = (q.size() > 0) ? q.pop_front() : 17'h1dead;
      chk({pkt_right, pkt_data} == e, "R1/R2/R3 packet", {pkt_right, pkt_data}, e);
      pkt_ready = 1;
    end
  end

  task automatic slot(input logic w, input logic d);
    bck = 0; ws = w; sd = d;
    repeat (HALF) @(negedge clk);
    bck = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_chan(input logic s, input logic [31:0] v, input int n,
                           input logic nxt, input logic push);
    if (push) begin
      if (n == 32) begin q.push_back({s, v[31:16]}); q.push_back({s, v[15:0]}); end
      else q.push_back({s, v[15:0]});
    end
    for (int i = n - 1; i >= 0; i--) slot((i == 0) ? nxt : s, v[i]);
  endtask

  task automatic prelude();
    slot(1'b1, 1'b0);
    slot(1'b0, 1'b1);
  endtask

  task automatic pulse_stat();
    @(negedge clk) stat_rd = 1;
    @(negedge clk) stat_rd = 0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!pkt_valid, "R10 valid", pkt_valid, 0);
    chk(!ovr_flag,  "R10 ovr",   ovr_flag, 0);
    chk(!busy,      "R10 busy",  busy, 0);
    chk(!irq_rx && !irq_err, "R10 irq", {irq_rx, irq_err}, 0);

    // R11 disabled: no packet
    prelude();
    send_chan(1'b0, 32'h5a5a, 16, 1'b1, 1'b0);
    send_chan(1'b1, 32'ha5a5, 16, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk(!pkt_valid, "R11 no packet when disabled", pkt_valid, 0);
    chk(!busy, "R11 not busy", busy, 0);

    // R8 busy rise, R1/R3 16-bit frames, R2 32-bit frames
    rx_enable = 1; mon_en = 1;
    prelude();
    chk(busy, "R8 busy after start", busy, 1);
    send_chan(1'b0, 32'h1234, 16, 1'b1, 1'b1);
    send_chan(1'b1, 32'habcd, 16, 1'b0, 1'b1);
    send_chan(1'b0, 32'h8001, 16, 1'b1, 1'b1);
    send_chan(1'b1, 32'h7ffe, 16, 1'b0, 1'b1);
    send_chan(1'b0, 32'hdeadbeef, 32, 1'b1, 1'b1);
    send_chan(1'b1, 32'h0f0f3c3c, 32, 1'b0, 1'b1);
    drain();

    // R4/R5/R6/R7 back-pressure, overrun and clearing
    mon_en = 0; rxne_ie = 1; err_ie = 1;
    prelude();
    send_chan(1'b0, 32'hc001, 16, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    chk(pkt_valid, "R4 valid set", pkt_valid, 1);
    chk(irq_rx, "R4 irq_rx with enable", irq_rx, 1);
    rxne_ie = 0;
    @(negedge clk);
    chk(!irq_rx, "R4 irq_rx masked", irq_rx, 0);
    send_chan(1'b1, 32'hbeef, 16, 1'b0, 1'b0);
    send_chan(1'b0, 32'h4321, 16, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(ovr_flag, "R6 overrun set", ovr_flag, 1);
    chk(irq_err, "R6 irq_err", irq_err, 1);
    chk(pkt_data == 16'hc001 && !pkt_right, "R5/R6 held packet kept",
        {pkt_right, pkt_data}, 17'h0c001);
    pulse_stat();
    chk(ovr_flag, "R7 status read alone keeps ovr", ovr_flag, 1);
    mon_en = 1;
    drain();
    chk(!pkt_valid, "R5 read clears valid", pkt_valid, 0);
    chk(ovr_flag, "R7 data read alone keeps ovr", ovr_flag, 1);
    pulse_stat();
    @(negedge clk);
    chk(!ovr_flag, "R7 ovr cleared", ovr_flag, 0);
    chk(!irq_err, "R6 irq_err cleared", irq_err, 0);

    // R8 busy falls after disable at packet boundary
    rx_enable = 0;
    repeat (5) @(negedge clk);
    chk(!busy, "R8 busy cleared", busy, 0);

    // R9 master-receive code keeps busy low, packets flow
    cfg_mode = 2'b11; rx_enable = 1;
    prelude();
    chk(!busy, "R9 busy low in mode 11", busy, 0);
    send_chan(1'b0, 32'h0246, 16, 1'b1, 1'b1);
    chk(!busy, "R9 busy low mid frame", busy, 0);
    send_chan(1'b1, 32'h1357, 16, 1'b0, 1'b1);
    drain();
    chk(q.size() == 0, "R9 packets received", q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule